// File: doc/BRIEF.md
# HDLC Transmit Framer with Preamble

This block turns a byte stream into a serial HDLC bit stream. Bytes arrive on a valid/ready handshake, and a marker flags the last byte of each frame. The block sends the flag pattern 0x7E between frames as timefill. It sends frame bytes least significant bit first, puts a zero after every run of five ones in the frame content, and appends a frame check sequence. One bit leaves on `tx_bit` for each clock cycle in which `bit_en` is high, so a slower line rate is set by how often `bit_en` is pulsed.

The frame check sequence is either 16-bit CRC-CCITT or 32-bit CRC-32. Optionally, a programmable 8-bit pattern can be sent a chosen number of times before each frame, and these pattern bits are never stuffed. In shared-flag mode, one flag both closes a frame and opens the next. In separate mode, each frame has its own closing and opening flag.

The controller has five states:
- `S_FLAG` sends a timefill or opening flag.
- `S_PRE` sends one copy of the preamble.
- `S_DATA` sends a frame byte.
- `S_FCS` sends one byte of the check sequence.
- `S_CLOSE` sends a closing flag.

All transitions happen at a byte boundary:
- `S_FLAG` moves to `S_PRE` when a frame is pending and the preamble is enabled. It moves to `S_DATA` when a frame is pending and the preamble is off. Otherwise it stays in `S_FLAG`.
- `S_PRE` repeats until the last copy is sent, then moves to `S_DATA`.
- `S_DATA` repeats until the last byte, then moves to `S_FCS`.
- `S_FCS` repeats until the last check byte, then moves to `S_CLOSE`.
- `S_CLOSE` moves to `S_PRE` or `S_DATA` when shared flags are on and a frame is pending. Otherwise it moves to `S_FLAG`.

Top module: `hdlc_tx_framer`

## Requirements
- R1: While `rst_n` is low, `tx_bit` is 1 and `in_ready` is 0. The first bit sent after reset is bit 0 of a flag.
- R2: When no frame is pending, complete flags 0x7E are sent back to back, least significant bit first (0,1,1,1,1,1,1,0). Flags are never stuffed.
- R3: A byte is taken at a clock edge where both `in_valid` and `in_ready` are high. Its bits are sent least significant bit first, one per `bit_en` cycle. `tx_bit` changes only after a clock edge with `bit_en` high. A frame never starts in the middle of a flag or preamble copy.
- R4: After five consecutive ones within the frame bytes and check sequence, one extra 0 is sent. This also applies when the run of five ends on the last check bit, just before the closing flag.
- R5: With `cfg_crc32` = 0, the check sequence is 16 bits. The polynomial is 0x1021, processed bit-reflected (0x8408). The register is preset to 0xFFFF, and the complemented remainder is sent least significant bit first. For "123456789" the bytes sent are 0x6E then 0x90.
- R6: With `cfg_crc32` = 1, the check sequence is 32 bits. The polynomial is 0x04C11DB7, processed reflected (0xEDB88320). The register is preset to all ones, and the complemented remainder is sent least significant bit first.
- R7: The check covers exactly the bytes of its own frame, from the first byte through the last. It excludes flags, preamble and stuffed zeros, and restarts for every frame.
- R8: With `cfg_share_flag` = 1 and the next frame already pending when a closing flag ends, the next frame's preamble or first byte follows that flag directly.
- R9: With `cfg_share_flag` = 0, each frame gets its own opening flag after the previous closing flag, so two flags sit between consecutive frames.
- R10: With `cfg_pre_en` = 1, `cfg_pre_pattern` is sent `cfg_pre_reps`+1 times, least significant bit first, after the last flag and before the first frame bit. A value of 0 means one copy and 15 means sixteen.
- R11: Preamble bits are never stuffed. A pattern of 0xFF goes out as eight plain ones per copy.
- R12: `in_ready` is high only in a cycle with `bit_en` high, at the last bit of a flag, preamble copy or non-final byte that leads into frame data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | Bit-rate enable; one output bit per high cycle |
| cfg_share_flag | input | 1 | 1: one flag closes a frame and opens the next |
| cfg_pre_en | input | 1 | 1: send the preamble before each frame |
| cfg_pre_pattern | input | 8 | Preamble pattern |
| cfg_pre_reps | input | 4 | Preamble copies minus one |
| cfg_crc32 | input | 1 | 0: 16-bit check, 1: 32-bit check |
| in_data | input | 8 | Frame byte |
| in_valid | input | 1 | `in_data` holds a byte |
| in_last | input | 1 | This byte ends its frame |
| in_ready | output | 1 | Byte is taken at this edge |
| tx_bit | output | 1 | Serial line output |

## Verification
The assertions assume that, once a frame has begun, `in_valid` stays high until its last byte has been taken, since underrun handling is not part of this block. They also assume that the configuration inputs change only while reset is held. The bench loads every frame of a run into its queue before releasing reset. It changes the configuration only while reset is low, so the handshake is never starved and no setting moves in the middle of a stream. Each run sweeps one combination of shared flags, preamble enable and check width, using two `bit_en` rates.

// File: rtl/hdlc_tx_pkg.sv
`timescale 1ns/1ps
package hdlc_tx_pkg;
    localparam int BYTE_W = 8;
    localparam logic [BYTE_W-1:0] FLAG_BYTE = 8'h7E;
    localparam logic [31:0] POLY16_REFL = 32'h0000_8408;
    localparam logic [31:0] POLY32_REFL = 32'hEDB8_8320;

    typedef enum logic [2:0] {
        S_FLAG,
        S_PRE,
        S_DATA,
        S_FCS,
        S_CLOSE
    } tx_state_t;
endpackage

// File: rtl/hdlc_tx_crc.sv
`timescale 1ns/1ps
module hdlc_tx_crc
    import hdlc_tx_pkg::*;
#(
    parameter int CRC_W = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic preset,
    input  logic step_data,
    input  logic step_shift,
    input  logic din,
    input  logic sel32,
    output logic fcs_bit
);
    localparam logic [CRC_W-1:0] SEED16 = CRC_W'(32'h0000_FFFF);
    localparam logic [CRC_W-1:0] SEED32 = '1;

    logic [CRC_W-1:0] crc_q;
    logic [CRC_W-1:0] poly;
    logic [CRC_W-1:0] seed;

    assign poly    = sel32 ? CRC_W'(POLY32_REFL) : CRC_W'(POLY16_REFL);
    assign seed    = sel32 ? SEED32 : SEED16;
    assign fcs_bit = ~crc_q[0];

    always_ff @(posedge clk) begin
        if (!rst_n || preset) begin
            crc_q <= seed;
        end else if (step_data) begin
            crc_q <= (crc_q >> 1) ^ (((crc_q[0] ^ din) == 1'b1) ? poly : '0);
        end else if (step_shift) begin
            crc_q <= crc_q >> 1;
        end
    end

    // R5: in 16-bit mode the upper half of the register never fills
    a_r5_upper_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !sel32 |-> (crc_q[CRC_W-1:16] == '0));
endmodule

// File: rtl/hdlc_tx_stuff.sv
`timescale 1ns/1ps
module hdlc_tx_stuff #(
    parameter int RUN_LEN = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_en,
    input  logic count_en,
    input  logic bit_in,
    output logic stuff
);
    localparam int ONES_W = $clog2(RUN_LEN + 1);

    logic [ONES_W-1:0] ones_q;

    assign stuff = (ones_q == ONES_W'(RUN_LEN));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ones_q <= '0;
        end else if (bit_en) begin
            if (stuff)
                ones_q <= '0;
            else if (count_en && bit_in)
                ones_q <= ones_q + 1'b1;
            else
                ones_q <= '0;
        end
    end

    // R4: the run counter never passes the stuffing threshold
    a_r4_run_bound: assert property (@(posedge clk) disable iff (!rst_n)
        ones_q <= ONES_W'(RUN_LEN));
endmodule

// File: rtl/hdlc_tx_framer.sv
`timescale 1ns/1ps
module hdlc_tx_framer
    import hdlc_tx_pkg::*;
#(
    parameter int REP_W   = 4,
    parameter int RUN_LEN = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic              cfg_share_flag,
    input  logic              cfg_pre_en,
    input  logic [BYTE_W-1:0] cfg_pre_pattern,
    input  logic [REP_W-1:0]  cfg_pre_reps,
    input  logic              cfg_crc32,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              in_valid,
    input  logic              in_last,
    output logic              in_ready,
    output logic              tx_bit
);
    localparam int BIT_W = $clog2(BYTE_W);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(BYTE_W - 1);

    tx_state_t         state, state_nx;
    logic [BIT_W-1:0]  bit_idx;
    logic [BYTE_W-1:0] shreg;
    logic              last_q;
    logic [REP_W-1:0]  rep_idx;
    logic [1:0]        fcs_idx;
    logic [1:0]        fcs_top;
    logic              cur_bit, stuff, adv, byte_end, take, fcs_bit;
    logic              in_frame, in_data_st, in_fcs_st;

    assign fcs_top    = cfg_crc32 ? 2'd3 : 2'd1;
    assign adv        = bit_en && !stuff;
    assign byte_end   = adv && (bit_idx == LAST_BIT);
    assign in_data_st = (state == S_DATA);
    assign in_fcs_st  = (state == S_FCS);
    assign in_frame   = in_data_st || in_fcs_st;
    assign in_ready   = take;

    always_comb begin
        unique case (state)
            S_FLAG, S_CLOSE: cur_bit = FLAG_BYTE[bit_idx];
            S_PRE:           cur_bit = cfg_pre_pattern[bit_idx];
            S_DATA:          cur_bit = shreg[bit_idx];
            S_FCS:           cur_bit = fcs_bit;
            default:         cur_bit = 1'b1;
        endcase
    end

    // next-state decision, made only at byte boundaries
    always_comb begin
        state_nx = state;
        take     = 1'b0;
        if (byte_end) begin
            unique case (state)
                S_FLAG: begin
                    if (in_valid) begin
                        if (cfg_pre_en) begin
                            state_nx = S_PRE;
                        end else begin
                            state_nx = S_DATA;
                            take     = 1'b1;
                        end
                    end
                end
                S_PRE: begin
                    if (rep_idx == cfg_pre_reps) begin
                        state_nx = S_DATA;
                        take     = 1'b1;
                    end
                end
                S_DATA: begin
                    if (last_q) state_nx = S_FCS;
                    else        take     = 1'b1;
                end
                S_FCS: begin
                    if (fcs_idx == fcs_top) state_nx = S_CLOSE;
                end
                S_CLOSE: begin
                    if (in_valid && cfg_share_flag) begin
                        if (cfg_pre_en) begin
                            state_nx = S_PRE;
                        end else begin
                            state_nx = S_DATA;
                            take     = 1'b1;
                        end
                    end else begin
                        state_nx = S_FLAG;
                    end
                end
                default: state_nx = S_FLAG;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_FLAG;
        else        state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_bit  <= 1'b1;
            bit_idx <= '0;
            shreg   <= '0;
            last_q  <= 1'b0;
            rep_idx <= '0;
            fcs_idx <= '0;
        end else if (bit_en) begin
            tx_bit <= stuff ? 1'b0 : cur_bit;
            if (adv) bit_idx <= bit_idx + 1'b1;
            if (take) begin
                shreg  <= in_data;
                last_q <= in_last;
            end
            if (byte_end) begin
                rep_idx <= (state == S_PRE) ? rep_idx + 1'b1 : '0;
                fcs_idx <= in_fcs_st ? fcs_idx + 1'b1 : 2'd0;
            end
        end
    end

    hdlc_tx_crc #(.CRC_W(32)) u_crc (
        .clk        (clk),
        .rst_n      (rst_n),
        .preset     (!in_frame),
        .step_data  (adv && in_data_st),
        .step_shift (adv && in_fcs_st),
        .din        (shreg[bit_idx]),
        .sel32      (cfg_crc32),
        .fcs_bit    (fcs_bit)
    );

    hdlc_tx_stuff #(.RUN_LEN(RUN_LEN)) u_stuff (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_en   (bit_en),
        .count_en (in_frame),
        .bit_in   (cur_bit),
        .stuff    (stuff)
    );

    // R12: bytes are only taken on bit-enable cycles
    a_r12_ready_on_en: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> bit_en);
    // R3: the line holds its value between enables
    a_r3_hold_line: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> $stable(tx_bit));
    // R4: a stuffing step puts a zero on the line
    a_r4_zero_after_run: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && stuff) |=> !tx_bit);
    // R5: the 16-bit check never reaches a third byte
    a_r5_fcs16_len: assert property (@(posedge clk) disable iff (!rst_n)
        (in_fcs_st && !cfg_crc32) |-> (fcs_idx <= 2'd1));
    // R10: the preamble copy index stays within the programmed count
    a_r10_rep_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_PRE) |-> (rep_idx <= cfg_pre_reps));
    // R3: input assumption, a started frame is never starved
    a_r3_valid_held: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == S_PRE) || (in_data_st && !last_q)) |-> in_valid);
endmodule

// File: tb/hdlc_tx_framer_tb.sv
`timescale 1ns/1ps
module hdlc_tx_framer_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_en = 1'b0;
    logic       share = 1'b0, pre_en = 1'b0, crc32 = 1'b0;
    logic [7:0] pat = 8'h00;
    logic [3:0] reps = 4'd0;
    logic [7:0] in_data = 8'h00;
    logic       in_valid = 1'b0, in_last = 1'b0;
    logic       in_ready, tx_bit;
    logic       hs = 1'b0;

    int n_cmp = 0, n_bad = 0;
    bit exp_q[$];
    int tag_q[$];
    bit got_q[$];
    logic [7:0] qd[$];
    bit ql[$];
    logic [7:0] fr[$];

    hdlc_tx_framer u_dut (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en),
        .cfg_share_flag(share), .cfg_pre_en(pre_en),
        .cfg_pre_pattern(pat), .cfg_pre_reps(reps), .cfg_crc32(crc32),
        .in_data(in_data), .in_valid(in_valid), .in_last(in_last),
        .in_ready(in_ready), .tx_bit(tx_bit)
    );

    always #5 clk = ~clk;
    always @(posedge clk) hs <= in_valid && in_ready;

    function automatic string rname(int t);
        case (t)
            1: return "R1";   2: return "R2";   3: return "R3";
            4: return "R4";   5: return "R5+R7"; 6: return "R6+R7";
            8: return "R8";   9: return "R9";   10: return "R10";
            11: return "R11"; 12: return "R12";
            default: return "R?";
        endcase
    endfunction

    task automatic chk(bit ok, int t, string what, int act, int expv);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: got %0d expected %0d", rname(t), what, act, expv);
        end
    endtask

    task automatic push_byte(logic [7:0] b, int t);
        for (int i = 0; i < 8; i++) begin
            exp_q.push_back(b[i]);
            tag_q.push_back(t);
        end
    endtask

    // expected bits of the frame in fr: data, check, zero insertion (R4, R7)
    task automatic push_frame();
        logic [31:0] c, poly;
        bit raw[$];
        int rtag[$];
        int nb, ones;
        c    = crc32 ? 32'hFFFF_FFFF : 32'h0000_FFFF;
        poly = crc32 ? 32'hEDB8_8320 : 32'h0000_8408;
        foreach (fr[k]) begin
            for (int i = 0; i < 8; i++) begin
                bit fbk;
                raw.push_back(fr[k][i]);
                rtag.push_back(3);
                fbk = c[0] ^ fr[k][i];
                c = c >> 1;
                if (fbk) c = c ^ poly;
            end
            qd.push_back(fr[k]);
            ql.push_back(k == fr.size() - 1);
        end
        c  = ~c;
        nb = crc32 ? 32 : 16;
        for (int i = 0; i < nb; i++) begin
            raw.push_back(c[i]);
            rtag.push_back(crc32 ? 6 : 5);
        end
        ones = 0;
        foreach (raw[i]) begin
            exp_q.push_back(raw[i]);
            tag_q.push_back(rtag[i]);
            ones = raw[i] ? ones + 1 : 0;
            if (ones == 5) begin
                exp_q.push_back(1'b0);
                tag_q.push_back(4);
                ones = 0;
            end
        end
    endtask

    task automatic drive_inputs();
        in_valid = (qd.size() > 0);
        in_data  = (qd.size() > 0) ? qd[0] : 8'h00;
        in_last  = (ql.size() > 0) ? ql[0] : 1'b0;
    endtask

    task automatic run_scenario(int sc);
        bit every, en_prev, last_tx;
        int cyc, guard;
        rst_n  = 1'b0;
        bit_en = 1'b0;
        share  = sc[0];
        pre_en = sc[1];
        crc32  = sc[2];
        pat    = (sc == 3 || sc == 7) ? 8'hFF : (8'h3C ^ 8'(sc));
        reps   = 4'((sc * 5) % 16);
        every  = (sc == 1 || sc == 2 || sc == 5 || sc == 6);
        exp_q.delete(); tag_q.delete(); got_q.delete();
        qd.delete(); ql.delete();
        push_byte(8'h7E, 1);
        for (int f = 0; f < 3; f++) begin
            fr.delete();
            if (f == 0) begin
                for (int i = 0; i < 9; i++) fr.push_back(8'h31 + 8'(i));
            end else if (f == 1) begin
                fr.push_back(8'hFF);
            end else begin
                fr.push_back(8'h7E); fr.push_back(8'hF8);
                fr.push_back(8'h1F); fr.push_back(8'(sc));
            end
            if (f > 0 && !share) push_byte(8'h7E, 9);
            if (pre_en)
                for (int r = 0; r <= int'(reps); r++) push_byte(pat, (pat == 8'hFF) ? 11 : 10);
            push_frame();
            push_byte(8'h7E, (f < 2 && share) ? 8 : 2);
        end
        for (int i = 0; i < 3; i++) push_byte(8'h7E, 2);
        drive_inputs();
        repeat (3) @(negedge clk);
        chk(tx_bit == 1'b1, 1, "reset line level", tx_bit, 1);
        chk(in_ready == 1'b0, 1, "reset ready", in_ready, 0);
        rst_n   = 1'b1;
        en_prev = 1'b0;
        last_tx = tx_bit;
        cyc = 0; guard = 0;
        while (got_q.size() < exp_q.size() && guard < 20000) begin
            @(negedge clk);
            guard++;
            if (en_prev) got_q.push_back(tx_bit);
            else chk(tx_bit == last_tx, 3, "line held without enable", tx_bit, last_tx);
            last_tx = tx_bit;
            if (hs) begin
                void'(qd.pop_front());
                void'(ql.pop_front());
            end
            drive_inputs();
            bit_en  = every ? 1'b1 : (cyc % 3 == 0);
            en_prev = bit_en;
            cyc++;
            #1;
            if (!bit_en) chk(in_ready == 1'b0, 12, "ready without enable", in_ready, 0);
        end
        chk(got_q.size() >= exp_q.size(), 3, $sformatf("sc%0d stream length", sc),
            got_q.size(), exp_q.size());
        foreach (exp_q[i])
            if (i < got_q.size())
                chk(got_q[i] == exp_q[i], tag_q[i], $sformatf("sc%0d bit%0d", sc, i),
                    got_q[i], exp_q[i]);
        chk(qd.size() == 0, 12, $sformatf("sc%0d bytes left", sc), qd.size(), 0);
    endtask

    initial begin
        for (int sc = 0; sc < 8; sc++) run_scenario(sc);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #2000000;
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule